// File: doc/BRIEF.md
# Processor Status Register with Interrupt Gate

This block holds the eight status bits of a small processor core: a global interrupt enable, a single-bit transfer latch, and the arithmetic flags half-carry, sign, overflow, negative, zero and carry. The ALU updates the arithmetic flags through a separate write enable for each flag. A bus port writes the whole byte in one cycle. Separate strobes set or clear the interrupt enable, mark that an interrupt has been accepted, and mark a return from an interrupt handler. The sign flag is not stored. It is always formed as negative xor overflow.

The enable also gates the core's interrupt requests. Each request line is passed on only when the global enable is 1 and that line's own enable is 1. Two single-bit moves use the transfer latch. A bit-store copies one selected bit of an operand into the latch. A bit-load returns a second operand with the selected bit replaced by the latch. The bit-load result is combinational.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset the register value `sreg` reads 0x00.
- R2: The byte layout from bit 7 to bit 0 is: enable, transfer, half-carry, sign, overflow, negative, zero, carry. A bus write (`bus_we`) loads every stored bit from the same position of `bus_wdata`, and the result is visible one cycle later.
- R3: `irq_out[k]` equals `irq_req[k] & irq_en[k]` while the enable (bit 7) is 1. While the enable is 0, `irq_out` is all zeros. The gating is combinational from the current register value.
- R4: `irq_accept` while the enable is 1 clears the enable on the next edge. In that cycle it takes precedence over a bus write and over the set, clear and return strobes. The other bits still take their normal updates.
- R5: `ie_set` or `irq_return` sets the enable, and `ie_clr` clears it. When `ie_clr` and a set or return strobe arrive together, the clear wins. A bus write in the same cycle takes precedence over all three.
- R6: Bit 4 (sign) always reads as bit 2 xor bit 3, including after a bus write. The value written to bit 4 has no effect.
- R7: `alu_we`/`alu_flags` bits 4..0 map to half-carry, overflow, negative, zero and carry, in that order. A flag whose enable bit is 1 takes the supplied value. A flag whose enable bit is 0 holds its value. A bus write overrides any ALU update in the same cycle.
- R8: `bst_en` copies `bst_src[bit_sel]` into the transfer bit (bit 6). A bus write in the same cycle takes precedence.
- R9: `bld_result` equals `bld_src` with bit `bit_sel` replaced by the transfer bit. All other bits pass through unchanged.
- R10: `irq_accept` while the enable is 0 is ignored. With no other strobe present, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_we | input | 5 | Per-flag ALU write enables {H,V,N,Z,C} |
| alu_flags | input | 5 | ALU flag values {H,V,N,Z,C} |
| bus_we | input | 1 | Full-byte bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| ie_set | input | 1 | Set interrupt enable |
| ie_clr | input | 1 | Clear interrupt enable |
| irq_accept | input | 1 | Interrupt taken this cycle |
| irq_return | input | 1 | Return from interrupt handler |
| bst_en | input | 1 | Bit-store into transfer bit |
| bst_src | input | 8 | Bit-store operand |
| bit_sel | input | 3 | Selected bit index for store and load |
| bld_src | input | 8 | Bit-load operand |
| bld_result | output | 8 | Bit-load result |
| irq_req | input | IRQ_N | Raw interrupt requests |
| irq_en | input | IRQ_N | Per-line interrupt enables |
| irq_out | output | IRQ_N | Gated interrupt requests |
| sreg | output | 8 | Current register value |

## Verification
The hardest situations to reach are the cycles where several writers compete for the enable bit. Examples are an accept strobe arriving together with a bus write that sets bit 7, or a clear arriving with a return. Each case only shows anything if the enable already has the state that lets the higher-priority source win. The stimulus therefore first puts the enable into a known state with a bus write or a set strobe. It then fires the competing strobes in a single cycle and reads the byte on the following cycle. A reference model in the bench, built from the requirements alone, predicts that byte. The accept-while-disabled case is reached the same way, after the enable has first been cleared.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int DATA_W   = 8;
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int ALU_FLAGS = 5;

    // Bit positions of the architectural byte (software decodes these)
    localparam int POS_IE    = 7;
    localparam int POS_XFER  = 6;
    localparam int POS_HALF  = 5;
    localparam int POS_SIGN  = 4;
    localparam int POS_OVF   = 3;
    localparam int POS_NEG   = 2;
    localparam int POS_ZERO  = 1;
    localparam int POS_CARRY = 0;

    // Stored state; sign is never stored
    typedef struct packed {
        logic                 ie;
        logic                 xfer;
        logic [ALU_FLAGS-1:0] arith;   // {half, ovf, neg, zero, carry}
    } psr_state_t;

    function automatic logic [DATA_W-1:0] psr_view(input psr_state_t s);
        logic [DATA_W-1:0] v;
        v             = '0;
        v[POS_IE]     = s.ie;
        v[POS_XFER]   = s.xfer;
        v[POS_HALF]   = s.arith[4];
        v[POS_OVF]    = s.arith[3];
        v[POS_NEG]    = s.arith[2];
        v[POS_ZERO]   = s.arith[1];
        v[POS_CARRY]  = s.arith[0];
        v[POS_SIGN]   = s.arith[2] ^ s.arith[3];
        return v;
    endfunction

endpackage

// File: rtl/psr_flag_merge.sv
module psr_flag_merge #(
    parameter int NFLAGS = 5
) (
    input  logic [NFLAGS-1:0] cur_flags,
    input  logic [NFLAGS-1:0] upd_we,
    input  logic [NFLAGS-1:0] upd_val,
    output logic [NFLAGS-1:0] merged
);
    for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
        assign merged[f] = upd_we[f] ? upd_val[f] : cur_flags[f];
    end
endmodule

// File: rtl/psr_bit_xfer.sv
module psr_bit_xfer #(
    parameter int W     = 8,
    localparam int IW   = $clog2(W)
) (
    input  logic [W-1:0]  store_src,
    input  logic [W-1:0]  load_src,
    input  logic [IW-1:0] sel,
    input  logic          xfer_bit,
    output logic          store_bit,
    output logic [W-1:0]  load_out
);
    assign store_bit = store_src[sel];

    for (genvar i = 0; i < W; i++) begin : g_ins
        assign load_out[i] = (sel == IW'(i)) ? xfer_bit : load_src[i];
    end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter int N = 8
) (
    input  logic         global_en,
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    output logic [N-1:0] gated
);
    for (genvar k = 0; k < N; k++) begin : g_line
        assign gated[k] = global_en & req[k] & en[k];
    end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import psr_pkg::*;
#(
    parameter int IRQ_N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ALU_FLAGS-1:0] alu_we,
    input  logic [ALU_FLAGS-1:0] alu_flags,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 ie_set,
    input  logic                 ie_clr,
    input  logic                 irq_accept,
    input  logic                 irq_return,
    input  logic                 bst_en,
    input  logic [DATA_W-1:0]    bst_src,
    input  logic [IDX_W-1:0]     bit_sel,
    input  logic [DATA_W-1:0]    bld_src,
    output logic [DATA_W-1:0]    bld_result,
    input  logic [IRQ_N-1:0]     irq_req,
    input  logic [IRQ_N-1:0]     irq_en,
    output logic [IRQ_N-1:0]     irq_out,
    output logic [DATA_W-1:0]    sreg
);
    psr_state_t           state_q, state_d;
    logic [ALU_FLAGS-1:0] alu_merged;
    logic                 store_bit;
    logic [ALU_FLAGS-1:0] bus_arith;

    assign bus_arith = {bus_wdata[POS_HALF], bus_wdata[POS_OVF], bus_wdata[POS_NEG],
                        bus_wdata[POS_ZERO], bus_wdata[POS_CARRY]};

    psr_flag_merge #(.NFLAGS(ALU_FLAGS)) u_merge (
        .cur_flags (state_q.arith),
        .upd_we    (alu_we),
        .upd_val   (alu_flags),
        .merged    (alu_merged)
    );

    psr_bit_xfer #(.W(DATA_W)) u_xfer (
        .store_src (bst_src),
        .load_src  (bld_src),
        .sel       (bit_sel),
        .xfer_bit  (state_q.xfer),
        .store_bit (store_bit),
        .load_out  (bld_result)
    );

    psr_irq_gate #(.N(IRQ_N)) u_gate (
        .global_en (state_q.ie),
        .req       (irq_req),
        .en        (irq_en),
        .gated     (irq_out)
    );

    always_comb begin
        state_d = state_q;
        // enable: accept > bus > clear > set/return
        if (irq_accept && state_q.ie)
            state_d.ie = 1'b0;
        else if (bus_we)
            state_d.ie = bus_wdata[POS_IE];
        else if (ie_clr)
            state_d.ie = 1'b0;
        else if (ie_set || irq_return)
            state_d.ie = 1'b1;
        // transfer bit: bus > bit-store
        if (bus_we)
            state_d.xfer = bus_wdata[POS_XFER];
        else if (bst_en)
            state_d.xfer = store_bit;
        // arithmetic flags: bus > ALU
        state_d.arith = bus_we ? bus_arith : alu_merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign sreg = psr_view(state_q);

endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
    parameter int IRQ_N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       alu_we,
    input logic             bus_we,
    input logic [7:0]       bus_wdata,
    input logic             ie_set,
    input logic             ie_clr,
    input logic             irq_accept,
    input logic             irq_return,
    input logic             bst_en,
    input logic [2:0]       bit_sel,
    input logic [7:0]       bld_src,
    input logic [7:0]       bld_result,
    input logic [IRQ_N-1:0] irq_out,
    input logic [7:0]       sreg
);
    a_r4_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && sreg[7]) |=> !sreg[7]);

    a_r5_return_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_accept && !bus_we && !ie_clr) |=> sreg[7]);

    a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !sreg[7] |-> (irq_out == '0));

    a_r9_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((bld_result ^ bld_src) & ~(8'b1 << bit_sel)) == 8'h00);

    a_r2_bus_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (sreg[6:5] == $past(bus_wdata[6:5])) && (sreg[3:0] == $past(bus_wdata[3:0])));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !ie_set && !ie_clr && !irq_return && !bst_en && alu_we == '0 &&
         !(irq_accept && sreg[7])) |=> $stable(sreg));
endmodule

bind cpu_status_reg psr_checker #(.IRQ_N(IRQ_N)) u_psr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_we     (alu_we),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .ie_set     (ie_set),
    .ie_clr     (ie_clr),
    .irq_accept (irq_accept),
    .irq_return (irq_return),
    .bst_en     (bst_en),
    .bit_sel    (bit_sel),
    .bld_src    (bld_src),
    .bld_result (bld_result),
    .irq_out    (irq_out),
    .sreg       (sreg)
);

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;
    localparam int NI = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] alu_we = '0, alu_flags = '0;
    logic bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic ie_set = 1'b0, ie_clr = 1'b0, irq_accept = 1'b0, irq_return = 1'b0;
    logic bst_en = 1'b0;
    logic [7:0] bst_src = '0, bld_src = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] bld_result;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic [NI-1:0] irq_out;
    logic [7:0] sreg;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic m_i = 0, m_t = 0, m_h = 0, m_v = 0, m_n = 0, m_z = 0, m_c = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    cpu_status_reg #(.IRQ_N(NI)) uut (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_flags(alu_flags),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .ie_set(ie_set), .ie_clr(ie_clr),
        .irq_accept(irq_accept), .irq_return(irq_return), .bst_en(bst_en),
        .bst_src(bst_src), .bit_sel(bit_sel), .bld_src(bld_src),
        .bld_result(bld_result), .irq_req(irq_req), .irq_en(irq_en),
        .irq_out(irq_out), .sreg(sreg)
    );

    function automatic logic [7:0] model_byte();
        return {m_i, m_t, m_h, m_n ^ m_v, m_v, m_n, m_z, m_c};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_we = '0; alu_flags = '0; bus_we = 0; bus_wdata = '0;
        ie_set = 0; ie_clr = 0; irq_accept = 0; irq_return = 0;
        bst_en = 0; bst_src = '0; bit_sel = '0; bld_src = '0;
    endtask

    // Driver: call after setting inputs at a negedge; predicts next byte
    task automatic apply(string req);
        logic ni, nt;
        logic [4:0] fl;
        ni = m_i;
        if (irq_accept && m_i)        ni = 1'b0;
        else if (bus_we)              ni = bus_wdata[7];
        else if (ie_clr)              ni = 1'b0;
        else if (ie_set || irq_return) ni = 1'b1;
        nt = m_t;
        if (bus_we)      nt = bus_wdata[6];
        else if (bst_en) nt = bst_src[bit_sel];
        fl = {m_h, m_v, m_n, m_z, m_c};
        if (bus_we) fl = {bus_wdata[5], bus_wdata[3:0]};
        else for (int f = 0; f < 5; f++) if (alu_we[f]) fl[f] = alu_flags[f];
        m_i = ni; m_t = nt;
        {m_h, m_v, m_n, m_z, m_c} = fl;
        exp_q.push_back(model_byte());
        tag_q.push_back(req);
        @(negedge clk);
        idle();
    endtask

    // Monitor
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            #1;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'h0, sreg}, {24'h0, e});
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R1", {24'h0, sreg}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {24'h0, sreg}, 32'h0);
        irq_req = 8'hFF; irq_en = 8'hFF; #1;
        check("R3", {24'h0, irq_out}, 32'h0);

        // R2/R6: bus write all ones -> sign derived 0
        bus_we = 1; bus_wdata = 8'hFF; apply("R2");
        bus_we = 1; bus_wdata = 8'h10; apply("R6");
        bus_we = 1; bus_wdata = 8'hA5; apply("R2");
        bus_we = 1; bus_wdata = 8'h04; apply("R6");
        @(negedge clk);
        check("R6", {31'h0, sreg[4]}, 32'h1);

        // R7 ALU partial update
        alu_we = 5'b10001; alu_flags = 5'b11111; apply("R7");
        alu_we = 5'b01110; alu_flags = 5'b01010; apply("R7");
        alu_we = 5'b11111; alu_flags = 5'b00000; bus_we = 1; bus_wdata = 8'h0F; apply("R7");

        // R3 gating with enable on
        ie_set = 1; apply("R5");
        irq_req = 8'b1011_0110; irq_en = 8'b1110_0011; #1;
        check("R3", {24'h0, irq_out}, {24'h0, 8'b1010_0010});
        // R4 accept beats bus write of bit7
        irq_accept = 1; bus_we = 1; bus_wdata = 8'hC3; ie_set = 1; apply("R4");
        #1; check("R3", {24'h0, irq_out}, 32'h0);
        // R10 accept while disabled ignored
        irq_accept = 1; apply("R10");
        irq_return = 1; apply("R5");
        ie_clr = 1; irq_return = 1; apply("R5");
        ie_set = 1; ie_clr = 1; apply("R5");
        ie_set = 1; apply("R5");
        ie_clr = 1; bus_we = 1; bus_wdata = 8'h80; apply("R5");
        irq_accept = 1; alu_we = 5'b00001; alu_flags = 5'b00000; apply("R4");

        // R8 bit store, R9 bit load
        bst_en = 1; bst_src = 8'b0010_0000; bit_sel = 3'd5; apply("R8");
        bld_src = 8'h00; bit_sel = 3'd3; #1;
        check("R9", {24'h0, bld_result}, {24'h0, 8'h08});
        bld_src = 8'hFF; bit_sel = 3'd7; #1;
        check("R9", {24'h0, bld_result}, 32'hFF);
        idle();
        bst_en = 1; bst_src = 8'hFE; bit_sel = 3'd0; apply("R8");
        bld_src = 8'hFF; bit_sel = 3'd0; #1;
        check("R9", {24'h0, bld_result}, {24'h0, 8'hFE});
        bld_src = 8'h5A; bit_sel = 3'd6; #1;
        check("R9", {24'h0, bld_result}, {24'h0, 8'h1A});
        idle();
        bst_en = 1; bst_src = 8'h80; bit_sel = 3'd7; bus_we = 1; bus_wdata = 8'h00; apply("R8");

        // sweep of mixed patterns
        for (int k = 0; k < 24; k++) begin
            alu_we = 5'(k * 7); alu_flags = 5'(k * 13 + 3);
            bus_we = (k % 5 == 0); bus_wdata = 8'(k * 37);
            ie_set = (k % 3 == 0); ie_clr = (k % 4 == 1);
            irq_accept = (k % 6 == 2); irq_return = (k % 7 == 3);
            bst_en = (k % 2 == 1); bst_src = 8'(k * 29); bit_sel = 3'(k);
            apply("R7");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule